// File: doc/BRIEF.md
# Long-Mode Interrupt Entry Sequencer

This block carries out the delivery of one interrupt or exception while the processor runs in 64-bit mode. On a start pulse it captures the vector number, the interrupt table base, the two segment-table bases, the interrupted instruction pointer, stack pointer, flags, code and stack selectors and the current privilege level. It then walks a fixed series of memory accesses over a single-outstanding request/acknowledge port: two reads for the 16-byte gate, one read for the target code-segment descriptor, two probe reads of the future stack frame and five quadword stores that build that frame.

Every check (gate type, canonical target, stack-switch request, privilege change) is settled before the first store, so a failing delivery ends with a general-protection fault pulse or an unsupported pulse and leaves memory untouched. A successful delivery ends with a single done pulse together with the new instruction pointer, stack pointer, code selector and flags, which the surrounding core commits.

Top module: `lmi_entry_seq`

## Requirements
- R1: After an accepted start the first read is at idt_base_i + vector_i*16 (gate low quadword) and the second at that address + 8 (gate high quadword).
- R2: When (gate_low[43:40] AND 4'hE) differs from 4'hE the block raises fault_o with fault_code_o = 0 after exactly the two gate reads, and issues no store.
- R3: The third read fetches the code-segment descriptor at (ldt_base_i if selector bit 2 is set, else gdt_base_i) + (selector AND 16'h00F8), where the selector is gate_low[31:16].
- R4: The target offset is {gate_high[31:0], gate_low[63:48], gate_low[15:0]}; when its bits 63:47 are not all equal the block raises fault_o with fault_code_o = 0 after three reads and issues no store.
- R5: A nonzero stack-table index gate_low[34:32] ends the delivery with unsup_o after three reads and no store, even when a privilege change is also present.
- R6: When the target descriptor privilege field (descriptor bits 46:45) differs from cpl_i the delivery ends with unsup_o after three reads and no store.
- R7: The new stack pointer is (rsp_i - 40) with bits 3:0 cleared; the fourth and fifth reads probe that address and that address + 32, both before any store.
- R8: Five stores follow in ascending address order at new stack pointer + 0, 8, 16, 24, 32 holding rip_i, cs_i zero-extended, rflags_i, rsp_i and ss_i zero-extended.
- R9: After the fifth store done_o pulses with new_rip_o equal to the target offset, new_cs_o equal to the gate selector and new_rsp_o equal to the new stack pointer.
- R10: new_rflags_o equals rflags_i with bits 8, 14 and 16 cleared and bit 9 replaced by gate_low[40].
- R11: A start pulse while a delivery is in progress is ignored: the running delivery completes with its own accesses and only one outcome pulse appears.
- R12: mem_req_o stays high with stable address, write enable and data until mem_ack_i; each accepted start yields exactly one one-cycle pulse on exactly one of done_o, fault_o, unsup_o, after which mem_req_o stays low.
- R13: While rst_n is low and after its release the block is idle: no memory request and no outcome pulse until a start arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a delivery (taken only while idle) |
| vector_i | input | VEC_W | Interrupt vector number |
| idt_base_i | input | 64 | Interrupt table base address |
| gdt_base_i | input | 64 | Global segment table base |
| ldt_base_i | input | 64 | Local segment table base |
| rip_i | input | 64 | Address of the interrupted instruction |
| rsp_i | input | 64 | Current stack pointer |
| rflags_i | input | 64 | Current flags |
| cs_i | input | 16 | Current code selector |
| ss_i | input | 16 | Current stack selector |
| cpl_i | input | 2 | Current privilege level |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Request is a store |
| mem_addr_o | output | 64 | Byte address of the quadword |
| mem_wdata_o | output | 64 | Store data |
| mem_ack_i | input | 1 | Memory acknowledge, one cycle |
| mem_rdata_i | input | 64 | Load data, valid with acknowledge |
| done_o | output | 1 | Delivery completed pulse |
| new_rip_o | output | 64 | Handler entry address |
| new_rsp_o | output | 64 | Stack pointer after the frame |
| new_cs_o | output | 16 | Handler code selector |
| new_rflags_o | output | 64 | Flags for the handler |
| fault_o | output | 1 | General-protection fault pulse |
| fault_code_o | output | 16 | Fault error code |
| unsup_o | output | 1 | Stack switch requested, not handled |

## Verification
The assertions assume a memory that raises mem_ack_i only while mem_req_o is high and for one cycle per access, and a start that is not relied upon while a delivery runs. The bench's memory model acknowledges every request exactly one cycle after it appears and drops the acknowledge in between, so the handshake assumption holds throughout. Input registers are driven at falling edges and held for the whole delivery, and the one deliberate second start during a delivery exercises only the ignore path.

// File: rtl/lmi_pkg.sv
package lmi_pkg;
    localparam int QW_BYTES    = 8;
    localparam int FRAME_SLOTS = 5;
    localparam int FRAME_BYTES = FRAME_SLOTS * QW_BYTES;
    localparam int ALIGN_LSB   = 4;
    localparam int CANON_MSB   = 47;
    localparam int DPL_LSB     = 45;
    localparam int SLOT_W      = $clog2(FRAME_SLOTS);
    localparam logic [3:0]  GATE_TYPE_MASK = 4'hE;
    localparam logic [15:0] GP_ERR_CODE    = 16'h0000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GLO,
        ST_GHI,
        ST_GCHK,
        ST_CSD,
        ST_VCHK,
        ST_PRB,
        ST_STO
    } seq_e;
endpackage

// File: rtl/lmi_gate_decode.sv
module lmi_gate_decode
    import lmi_pkg::*;
(
    input  logic [63:0] lo_i,
    input  logic [31:0] hi_i,
    output logic        type_ok_o,
    output logic [15:0] sel_o,
    output logic        use_ldt_o,
    output logic [63:0] tbl_off_o,
    output logic [63:0] target_o,
    output logic        canon_ok_o,
    output logic [2:0]  ist_o,
    output logic        if_bit_o
);
    localparam int HI_BITS = 64 - CANON_MSB;

    logic [HI_BITS-1:0] upper;
    logic               unused_gate_bits;

    assign type_ok_o  = (lo_i[43:40] & GATE_TYPE_MASK) == GATE_TYPE_MASK;
    assign sel_o      = lo_i[31:16];
    assign use_ldt_o  = lo_i[18];
    assign tbl_off_o  = {56'd0, lo_i[23:19], 3'b000};
    assign target_o   = {hi_i, lo_i[63:48], lo_i[15:0]};
    assign upper      = target_o[63:CANON_MSB];
    assign canon_ok_o = (&upper) | ~(|upper);
    assign ist_o      = lo_i[34:32];
    assign if_bit_o   = lo_i[40];

    // presence, gate privilege and reserved bits are not examined here
    assign unused_gate_bits = ^{lo_i[47:44], lo_i[39:35]};
endmodule

// File: rtl/lmi_flags_fix.sv
module lmi_flags_fix (
    input  logic [63:0] old_i,
    input  logic        if_bit_i,
    output logic [63:0] new_o
);
    localparam int TRAP_BIT   = 8;
    localparam int INTEN_BIT  = 9;
    localparam int NEST_BIT   = 14;
    localparam int RESUME_BIT = 16;
    localparam logic [63:0] CLR_MASK = (64'd1 << TRAP_BIT) | (64'd1 << INTEN_BIT)
                                     | (64'd1 << NEST_BIT) | (64'd1 << RESUME_BIT);

    assign new_o = (old_i & ~CLR_MASK) | ({63'd0, if_bit_i} << INTEN_BIT);
endmodule

// File: rtl/lmi_frame_slot.sv
module lmi_frame_slot
    import lmi_pkg::*;
(
    input  logic [SLOT_W-1:0] idx_i,
    input  logic [63:0]       rip_i,
    input  logic [15:0]       cs_i,
    input  logic [63:0]       flags_i,
    input  logic [63:0]       rsp_i,
    input  logic [15:0]       ss_i,
    output logic [63:0]       data_o
);
    always_comb begin
        case (idx_i)
            SLOT_W'(0): data_o = rip_i;
            SLOT_W'(1): data_o = {48'd0, cs_i};
            SLOT_W'(2): data_o = flags_i;
            SLOT_W'(3): data_o = rsp_i;
            SLOT_W'(4): data_o = {48'd0, ss_i};
            default:    data_o = '0;
        endcase
    end
endmodule

// File: rtl/lmi_entry_seq.sv
module lmi_entry_seq
    import lmi_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [VEC_W-1:0] vector_i,
    input  logic [63:0]      idt_base_i,
    input  logic [63:0]      gdt_base_i,
    input  logic [63:0]      ldt_base_i,
    input  logic [63:0]      rip_i,
    input  logic [63:0]      rsp_i,
    input  logic [63:0]      rflags_i,
    input  logic [15:0]      cs_i,
    input  logic [15:0]      ss_i,
    input  logic [1:0]       cpl_i,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic [63:0]      mem_addr_o,
    output logic [63:0]      mem_wdata_o,
    input  logic             mem_ack_i,
    input  logic [63:0]      mem_rdata_i,
    output logic             done_o,
    output logic [63:0]      new_rip_o,
    output logic [63:0]      new_rsp_o,
    output logic [15:0]      new_cs_o,
    output logic [63:0]      new_rflags_o,
    output logic             fault_o,
    output logic [15:0]      fault_code_o,
    output logic             unsup_o
);
    localparam logic [63:0] ALIGN_MASK = ~((64'd1 << ALIGN_LSB) - 64'd1);
    localparam logic [63:0] PROBE_HI   = 64'((FRAME_SLOTS - 1) * QW_BYTES);
    localparam logic [63:0] HI_QW_OFF  = 64'(QW_BYTES);
    localparam logic [63:0] FRAME_SUB  = 64'(FRAME_BYTES);

    typedef struct packed {
        seq_e              st;
        logic [SLOT_W-1:0] idx;
        logic [VEC_W-1:0]  vec;
        logic [63:0]       idt;
        logic [63:0]       gdt;
        logic [63:0]       ldt;
        logic [63:0]       rip;
        logic [63:0]       rsp;
        logic [63:0]       flags;
        logic [15:0]       cs;
        logic [15:0]       ss;
        logic [1:0]        cpl;
        logic [63:0]       glo;
        logic [31:0]       ghi;
        logic [1:0]        tdpl;
        logic [63:0]       frame;
        logic              done;
        logic              fault;
        logic              unsup;
        logic [15:0]       ecode;
        logic [63:0]       n_rip;
        logic [63:0]       n_rsp;
        logic [63:0]       n_flags;
        logic [15:0]       n_cs;
    } seq_state_t;

    seq_state_t st_q, st_d;

    logic        type_ok, use_ldt, canon_ok, if_bit;
    logic [15:0] sel;
    logic [63:0] tbl_off, target, flags_new, slot_data, gate_off;
    logic [2:0]  ist;

    lmi_gate_decode u_dec (
        .lo_i       (st_q.glo),
        .hi_i       (st_q.ghi),
        .type_ok_o  (type_ok),
        .sel_o      (sel),
        .use_ldt_o  (use_ldt),
        .tbl_off_o  (tbl_off),
        .target_o   (target),
        .canon_ok_o (canon_ok),
        .ist_o      (ist),
        .if_bit_o   (if_bit)
    );

    lmi_flags_fix u_flags (
        .old_i    (st_q.flags),
        .if_bit_i (if_bit),
        .new_o    (flags_new)
    );

    lmi_frame_slot u_slot (
        .idx_i   (st_q.idx),
        .rip_i   (st_q.rip),
        .cs_i    (st_q.cs),
        .flags_i (st_q.flags),
        .rsp_i   (st_q.rsp),
        .ss_i    (st_q.ss),
        .data_o  (slot_data)
    );

    assign gate_off = {{(64 - VEC_W - 4){1'b0}}, st_q.vec, 4'b0000};

    // memory port driven from registered state only
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        case (st_q.st)
            ST_GLO: begin
                mem_req_o  = 1'b1;
                mem_addr_o = st_q.idt + gate_off;
            end
            ST_GHI: begin
                mem_req_o  = 1'b1;
                mem_addr_o = st_q.idt + gate_off + HI_QW_OFF;
            end
            ST_CSD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = (use_ldt ? st_q.ldt : st_q.gdt) + tbl_off;
            end
            ST_PRB: begin
                mem_req_o  = 1'b1;
                mem_addr_o = st_q.frame + (st_q.idx[0] ? PROBE_HI : 64'd0);
            end
            ST_STO: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = st_q.frame + {{(61 - SLOT_W){1'b0}}, st_q.idx, 3'b000};
                mem_wdata_o = slot_data;
            end
            default: ;
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.fault = 1'b0;
        st_d.unsup = 1'b0;
        case (st_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    st_d.vec   = vector_i;
                    st_d.idt   = idt_base_i;
                    st_d.gdt   = gdt_base_i;
                    st_d.ldt   = ldt_base_i;
                    st_d.rip   = rip_i;
                    st_d.rsp   = rsp_i;
                    st_d.flags = rflags_i;
                    st_d.cs    = cs_i;
                    st_d.ss    = ss_i;
                    st_d.cpl   = cpl_i;
                    st_d.st    = ST_GLO;
                end
            end
            ST_GLO: begin
                if (mem_ack_i) begin
                    st_d.glo = mem_rdata_i;
                    st_d.st  = ST_GHI;
                end
            end
            ST_GHI: begin
                if (mem_ack_i) begin
                    st_d.ghi = mem_rdata_i[31:0];
                    st_d.st  = ST_GCHK;
                end
            end
            ST_GCHK: begin
                if (!type_ok) begin
                    st_d.fault = 1'b1;
                    st_d.ecode = GP_ERR_CODE;
                    st_d.st    = ST_IDLE;
                end else begin
                    st_d.st = ST_CSD;
                end
            end
            ST_CSD: begin
                if (mem_ack_i) begin
                    st_d.tdpl = mem_rdata_i[DPL_LSB+1:DPL_LSB];
                    st_d.st   = ST_VCHK;
                end
            end
            ST_VCHK: begin
                if (!canon_ok) begin
                    st_d.fault = 1'b1;
                    st_d.ecode = GP_ERR_CODE;
                    st_d.st    = ST_IDLE;
                end else if (ist != 3'd0) begin
                    st_d.unsup = 1'b1;
                    st_d.st    = ST_IDLE;
                end else if (st_q.tdpl != st_q.cpl) begin
                    st_d.unsup = 1'b1;
                    st_d.st    = ST_IDLE;
                end else begin
                    st_d.frame = (st_q.rsp - FRAME_SUB) & ALIGN_MASK;
                    st_d.idx   = '0;
                    st_d.st    = ST_PRB;
                end
            end
            ST_PRB: begin
                if (mem_ack_i) begin
                    if (st_q.idx == SLOT_W'(1)) begin
                        st_d.idx = '0;
                        st_d.st  = ST_STO;
                    end else begin
                        st_d.idx = st_q.idx + SLOT_W'(1);
                    end
                end
            end
            ST_STO: begin
                if (mem_ack_i) begin
                    if (st_q.idx == SLOT_W'(FRAME_SLOTS - 1)) begin
                        st_d.done    = 1'b1;
                        st_d.n_rip   = target;
                        st_d.n_rsp   = st_q.frame;
                        st_d.n_cs    = sel;
                        st_d.n_flags = flags_new;
                        st_d.idx     = '0;
                        st_d.st      = ST_IDLE;
                    end else begin
                        st_d.idx = st_q.idx + SLOT_W'(1);
                    end
                end
            end
            default: st_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o       = st_q.done;
    assign fault_o      = st_q.fault;
    assign unsup_o      = st_q.unsup;
    assign fault_code_o = st_q.ecode;
    assign new_rip_o    = st_q.n_rip;
    assign new_rsp_o    = st_q.n_rsp;
    assign new_cs_o     = st_q.n_cs;
    assign new_rflags_o = st_q.n_flags;
endmodule

// File: rtl/lmi_entry_chk.sv
module lmi_entry_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req_o,
    input logic        mem_we_o,
    input logic [63:0] mem_addr_o,
    input logic [63:0] mem_wdata_o,
    input logic        mem_ack_i,
    input logic        done_o,
    input logic        fault_o,
    input logic        unsup_o,
    input logic [63:0] new_rsp_o,
    input logic [63:0] new_rflags_o
);
    logic wrote_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                          wrote_q <= 1'b0;
        else if (done_o || fault_o || unsup_o) wrote_q <= 1'b0;
        else if (mem_req_o && mem_we_o && mem_ack_i) wrote_q <= 1'b1;
    end

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                      && $stable(mem_we_o) && $stable(mem_wdata_o)));

    // R12
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, fault_o, unsup_o}));

    // R12
    outcome_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fault_o || unsup_o) |=> !(done_o || fault_o || unsup_o));

    // R7
    frame_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (new_rsp_o[3:0] == 4'h0));

    // R10
    flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!new_rflags_o[8] && !new_rflags_o[14] && !new_rflags_o[16]));

    // R2
    no_fault_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> !wrote_q);

    // R5
    no_unsup_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unsup_o |-> !wrote_q);
endmodule

bind lmi_entry_seq lmi_entry_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_ack_i    (mem_ack_i),
    .done_o       (done_o),
    .fault_o      (fault_o),
    .unsup_o      (unsup_o),
    .new_rsp_o    (new_rsp_o),
    .new_rflags_o (new_rflags_o)
);

// File: tb/tb_lmi_entry_seq.sv
module tb_lmi_entry_seq;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] IDT = 64'h0000_0000_0010_0000;
    localparam logic [63:0] GDT = 64'h0000_0000_0020_0000;
    localparam logic [63:0] LDT = 64'h0000_0000_0030_0000;
    localparam logic [15:0] CS_V = 16'h0033;
    localparam logic [15:0] SS_V = 16'h002B;

    typedef struct packed {
        logic [7:0]  vec;
        logic [63:0] lo;
        logic [63:0] hi;
        logic [1:0]  dpl;
        logic [1:0]  cpl;
        logic [63:0] rsp;
        logic [63:0] flags;
        logic [1:0]  kind;   // 0 done, 1 fault, 2 unsupported
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{8'h20, 64'h1234_8E00_0010_5678, 64'h0, 2'd0, 2'd0, 64'h8008, 64'h0001_4302, 2'd0},
        '{8'h03, 64'h0000_8F00_001C_1000, 64'h0000_0000_FFFF_8000, 2'd3, 2'd3,
              64'h0000_7FFF_FFFF_F0FF, 64'h46, 2'd0},
        '{8'h0D, 64'h0000_8C00_0010_0000, 64'h0, 2'd0, 2'd0, 64'h9000, 64'h2, 2'd1},
        '{8'h41, 64'h0000_8600_0010_0000, 64'h0, 2'd0, 2'd0, 64'h9000, 64'h2, 2'd1},
        '{8'hFF, 64'h0000_8E00_0010_0000, 64'h0000_0000_0000_8000, 2'd0, 2'd0, 64'h9000, 64'h2, 2'd1},
        '{8'h11, 64'h0000_8E02_0010_0000, 64'h0, 2'd3, 2'd0, 64'h9000, 64'h2, 2'd2},
        '{8'h12, 64'h0000_8E00_0010_0000, 64'h0, 2'd3, 2'd0, 64'h9000, 64'h2, 2'd2},
        '{8'h00, 64'hFFFF_8E00_0028_0000, 64'h0000_0000_FFFF_FFFF, 2'd0, 2'd0,
              64'h1000_0010, 64'h0003_4202, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  vector = '0;
    logic [63:0] rip = '0, rsp = '0, rflags = '0;
    logic [1:0]  cpl = '0;
    logic        mem_req, mem_we, mem_ack;
    logic [63:0] mem_addr, mem_wdata, mem_rdata;
    logic        done, fault, unsup;
    logic [63:0] new_rip, new_rsp, new_rflags;
    logic [15:0] new_cs, fault_code;

    vec_t        cur;
    logic        log_clr = 1'b1;
    int          rd_n, wr_n;
    logic [63:0] rd_a [8];
    logic [63:0] wr_a [8];
    logic [63:0] wr_d [8];
    int          checks = 0, fails = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lmi_entry_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .vector_i(vector),
        .idt_base_i(IDT), .gdt_base_i(GDT), .ldt_base_i(LDT),
        .rip_i(rip), .rsp_i(rsp), .rflags_i(rflags), .cs_i(CS_V), .ss_i(SS_V), .cpl_i(cpl),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
        .done_o(done), .new_rip_o(new_rip), .new_rsp_o(new_rsp), .new_cs_o(new_cs),
        .new_rflags_o(new_rflags), .fault_o(fault), .fault_code_o(fault_code), .unsup_o(unsup)
    );

    function automatic logic [63:0] gate_addr(input logic [7:0] v);
        return IDT + {52'd0, v, 4'd0};
    endfunction

    function automatic logic [63:0] csd_addr(input logic [63:0] lo);
        return (lo[18] ? LDT : GDT) + {48'd0, lo[31:16] & 16'h00F8};
    endfunction

    function automatic logic [63:0] csd_val(input logic [1:0] dpl);
        return (64'h0020_9800_0000_0000 & ~(64'h3 << 45)) | ({62'd0, dpl} << 45);
    endfunction

    assign mem_rdata = (mem_addr == gate_addr(cur.vec))          ? cur.lo :
                       (mem_addr == gate_addr(cur.vec) + 64'd8)  ? cur.hi :
                       (mem_addr == csd_addr(cur.lo))            ? csd_val(cur.dpl) :
                                                                   64'hDEAD_BEEF_0BAD_F00D;

    always @(posedge clk) begin
        if (log_clr) begin
            rd_n <= 0; wr_n <= 0; mem_ack <= 1'b0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && mem_ack) begin
                if (mem_we) begin
                    if (wr_n < 8) begin wr_a[wr_n] <= mem_addr; wr_d[wr_n] <= mem_wdata; end
                    wr_n <= wr_n + 1;
                end else begin
                    if (rd_n < 8) rd_a[rd_n] <= mem_addr;
                    rd_n <= rd_n + 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // start one delivery; dup_at >= 0 fires a second start during it
    task automatic run(input vec_t v, input int dup_at, output int kind_seen, output int npulse);
        cur = v;
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
        vector = v.vec; rsp = v.rsp; rflags = v.flags; cpl = v.cpl;
        rip = 64'h0000_0040_0000_1000 + {56'd0, v.vec};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        kind_seen = -1; npulse = 0;
        for (int i = 0; i < 60; i++) begin
            if (i == dup_at) begin start = 1'b1; vector = 8'h0D; end
            else if (i == dup_at + 1) begin start = 1'b0; vector = v.vec; end
            @(negedge clk);
            if (done || fault || unsup) begin
                npulse++;
                if (kind_seen < 0) kind_seen = done ? 0 : (fault ? 1 : 2);
            end
        end
    endtask

    task automatic check_vector(input vec_t v, input int kind_seen, input int npulse);
        logic        type_bad;
        logic [63:0] frame, target, eflags, exp_rip;
        int          exp_rd;
        string       tag;
        type_bad = (v.lo[43:40] & 4'hE) != 4'hE;
        target   = {v.hi[31:0], v.lo[63:48], v.lo[15:0]};
        frame    = (v.rsp - 64'd40) & ~64'hF;
        eflags   = (v.flags & ~64'h0001_4300) | ({63'd0, v.lo[40]} << 9);
        exp_rip  = 64'h0000_0040_0000_1000 + {56'd0, v.vec};
        exp_rd   = (v.kind == 2'd0) ? 5 : (type_bad ? 2 : 3);
        tag = (v.kind == 2'd0) ? "R9" : (v.kind == 2'd1) ? (type_bad ? "R2" : "R4")
            : ((v.lo[34:32] != 3'd0) ? "R5" : "R6");
        chk({tag, " outcome kind"}, 64'(kind_seen), 64'(v.kind));
        chk("R12 single outcome pulse", 64'(npulse), 64'd1);
        chk("R1 gate low read address", rd_a[0], gate_addr(v.vec));
        chk("R1 gate high read address", rd_a[1], gate_addr(v.vec) + 64'd8);
        chk({tag, " read count"}, 64'(rd_n), 64'(exp_rd));
        chk({tag, " store count"}, 64'(wr_n), (v.kind == 2'd0) ? 64'd5 : 64'd0);
        chk("R12 request low after outcome", {63'd0, mem_req}, 64'd0);
        if (!type_bad)
            chk("R3 descriptor read address", rd_a[2], csd_addr(v.lo));
        if (v.kind == 2'd1)
            chk({tag, " fault code"}, {48'd0, fault_code}, 64'd0);
        if (v.kind == 2'd0) begin
            chk("R7 probe at frame base", rd_a[3], frame);
            chk("R7 probe at frame top", rd_a[4], frame + 64'd32);
            chk("R7 new stack pointer", new_rsp, frame);
            for (int k = 0; k < 5; k++)
                chk("R8 store address", wr_a[k], frame + 64'(8 * k));
            chk("R8 slot rip", wr_d[0], exp_rip);
            chk("R8 slot cs", wr_d[1], {48'd0, CS_V});
            chk("R8 slot flags", wr_d[2], v.flags);
            chk("R8 slot rsp", wr_d[3], v.rsp);
            chk("R8 slot ss", wr_d[4], {48'd0, SS_V});
            chk("R9 new rip", new_rip, target);
            chk("R9 new cs", {48'd0, new_cs}, {48'd0, v.lo[31:16]});
            chk("R10 new flags", new_rflags, eflags);
        end
    endtask

    initial begin
        int ks, np;
        // R13 reset state
        repeat (3) @(negedge clk);
        chk("R13 no request in reset", {63'd0, mem_req}, 64'd0);
        chk("R13 no pulse in reset", {61'd0, done, fault, unsup}, 64'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R13 idle after reset", {62'd0, mem_req, done}, 64'd0);

        for (int n = 0; n < NV; n++) begin
            run(TBL[n], -1, ks, np);
            check_vector(TBL[n], ks, np);
        end

        // R11 second start during a delivery is ignored
        run(TBL[0], 3, ks, np);
        check_vector(TBL[0], ks, np);
        chk("R11 no extra gate read", 64'(rd_n), 64'd5);

        // R13 reset in the middle of a delivery
        cur = TBL[1];
        log_clr = 1'b1; @(negedge clk); log_clr = 1'b0;
        vector = TBL[1].vec; rsp = TBL[1].rsp; rflags = TBL[1].flags; cpl = TBL[1].cpl;
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R13 request dropped by reset", {63'd0, mem_req}, 64'd0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R13 idle after mid-run reset", {60'd0, mem_req, done, fault, unsup}, 64'd0);
        run(TBL[1], -1, ks, np);
        check_vector(TBL[1], ks, np);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL R12 watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule